// File: doc/BRIEF.md
# Serial PCM Audio Transmitter

This block turns stereo audio sample pairs into a three-wire serial stream: a bit clock, a channel clock and a data line. Each sample word is up to 24 bits wide and is taken as a left/right pair through a valid/ready handshake. The bit clock comes from dividing the system clock by an even ratio. Serial data and the channel clock move on falling bit-clock transitions, so a receiver can sample them on the rising transition. A frame is one left slot followed by one right slot.

Static configuration inputs set how many bits of each word are sent and in which bit order. They also set the slot length and where the word sits inside its slot. The block samples these inputs, together with the divider ratio, only at the start of each frame. From reset until the first frame starts, the live values apply. If no pair is offered when a frame starts, the previous pair is sent again and an underrun indication stays high for that frame.

Top module: `pcm_tx`

## Requirements
- R1: `bclk` has a period of 2*N system clock cycles and a 50% duty cycle. N is `cfg_half_div`, and a value of 0 acts as 1.
- R2: `lrclk` is low for the left slot and high for the right slot. It changes only in the cycle where `bclk` falls.
- R3: `sdata` changes only in the cycle where `bclk` falls.
- R4: `cfg_prec` selects the word length: 0=16, 1=18, 2=20, 3=24 bits. The word sent is the most significant P bits of the 24-bit input sample, with bit 23 as the sample MSB.
- R5: With `cfg_lsb_first`=0 the word is sent MSB first. With `cfg_lsb_first`=1 it is sent LSB first.
- R6: A slot lasts 16 bit clocks when `cfg_short_slot`=1 and `cfg_prec`=0. In every other case it lasts 32 bit clocks.
- R7: With `cfg_right_align`=0 the word occupies the first P bit clocks of the slot. With `cfg_right_align`=1 it occupies the last P bit clocks. All other bit clocks of the slot carry 0.
- R8: `s_ready` is high for exactly one system cycle per frame: the cycle just before the `bclk` fall that opens a left slot. A pair is taken in that cycle if `s_valid` is high.
- R9: If `s_valid` is low in the `s_ready` cycle, the previous pair is sent again and `underrun` is 1 for the whole frame. `underrun` returns to 0 at the next frame that accepts a pair.
- R10: Configuration and divider inputs are sampled only when a frame starts. Changing them mid-frame does not alter the frame in progress.
- R11: During and after reset, before the first bit-clock edge: `bclk`=0, `lrclk`=1, `sdata`=0, `underrun`=0 and `s_ready`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_half_div | input | DIV_W | System cycles per bit-clock half period (0 acts as 1) |
| cfg_prec | input | 2 | Word length code |
| cfg_lsb_first | input | 1 | Bit order select |
| cfg_short_slot | input | 1 | Request 16-cycle slots (honoured only for 16-bit words) |
| cfg_right_align | input | 1 | Place word at the end of the slot |
| s_valid | input | 1 | Sample pair available |
| s_ready | output | 1 | Pair is taken this cycle |
| s_left | input | 24 | Left sample |
| s_right | input | 24 | Right sample |
| bclk | output | 1 | Serial bit clock |
| lrclk | output | 1 | Channel clock (0 = left) |
| sdata | output | 1 | Serial data |
| underrun | output | 1 | Current frame repeats the previous pair |

## Verification
The frame-start event is where several things meet in one system cycle. In that cycle the pair is accepted or refused, the configuration and divider are sampled, the slot counter wraps and the first data bit is driven. The bench provokes collisions by changing configuration, the divider ratio and `s_valid` at arbitrary cycles, including inside the `s_ready` cycle and halfway through a frame. A behavioural model builds the whole frame as a bit queue at each frame start and compares every output on every system cycle. Any value sampled at the wrong moment therefore shows up as a mismatch in the bit stream, the slot timing or the underrun flag.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
  localparam int SAMPLE_W = 24;
  localparam int POS_W    = 5;

  typedef struct packed {
    logic [1:0] prec;
    logic       lsb_first;
    logic       short_slot;
    logic       right_align;
  } fmt_t;

  function automatic int unsigned word_bits(logic [1:0] prec);
    case (prec)
      2'd0:    return 16;
      2'd1:    return 18;
      2'd2:    return 20;
      default: return 24;
    endcase
  endfunction

  function automatic int unsigned slot_cycles(fmt_t f);
    return (f.short_slot && f.prec == 2'd0) ? 32'd16 : 32'd32;
  endfunction

  // Value driven at slot position pos for sample smp under format f.
  function automatic logic slot_bit(logic [SAMPLE_W-1:0] smp, logic [POS_W-1:0] pos, fmt_t f);
    int unsigned p;
    int unsigned l;
    int unsigned first;
    int unsigned k;
    int unsigned ps;
    p     = word_bits(f.prec);
    l     = slot_cycles(f);
    first = f.right_align ? (l - p) : 32'd0;
    ps    = {27'd0, pos};
    if (ps < first || ps >= first + p) return 1'b0;
    k = ps - first;
    if (f.lsb_first) return smp[SAMPLE_W - p + k];
    return smp[SAMPLE_W - 1 - k];
  endfunction
endpackage

// File: rtl/pcm_tx_clkdiv.sv
module pcm_tx_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half,
  output logic             bclk,
  output logic             fall_evt
);
  logic [DIV_W-1:0] cnt;
  logic             half_done;

  assign half_done = (cnt >= half - 1'b1);
  assign fall_evt  = half_done && bclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else if (half_done) begin
      cnt  <= '0;
      bclk <= ~bclk;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end

  AST_DIV_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bclk) |-> (cnt == '0)); // R1
endmodule

// File: rtl/pcm_tx_seq.sv
module pcm_tx_seq
  import pcm_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall_evt,
  input  logic [POS_W-1:0] slot_last,
  output logic             frame_start,
  output logic [POS_W-1:0] pos_nxt,
  output logic             ch_nxt,
  output logic             lrclk
);
  logic [POS_W-1:0] pos;
  logic             ch;
  logic             at_last;

  assign at_last     = (pos >= slot_last);
  assign pos_nxt     = at_last ? '0 : pos + 1'b1;
  assign ch_nxt      = at_last ? ~ch : ch;
  assign frame_start = fall_evt && ch && at_last;
  assign lrclk       = ch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '1;
      ch  <= 1'b1;
    end else if (fall_evt) begin
      pos <= pos_nxt;
      ch  <= ch_nxt;
    end
  end

  AST_LEFT_OPENS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lrclk) |-> (pos == '0)); // R2
endmodule

// File: rtl/pcm_tx_ser.sv
module pcm_tx_ser
  import pcm_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fall_evt,
  input  logic                frame_start,
  input  logic                s_valid,
  input  logic [SAMPLE_W-1:0] s_left,
  input  logic [SAMPLE_W-1:0] s_right,
  input  logic                ch_nxt,
  input  logic [POS_W-1:0]    pos_nxt,
  input  fmt_t                fmt_nxt,
  output logic                sdata,
  output logic                underrun
);
  logic [SAMPLE_W-1:0] hold_l;
  logic [SAMPLE_W-1:0] hold_r;
  logic [SAMPLE_W-1:0] word_nxt;

  always_comb begin
    if (frame_start)  word_nxt = s_valid ? s_left : hold_l;
    else if (ch_nxt)  word_nxt = hold_r;
    else              word_nxt = hold_l;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_l   <= '0;
      hold_r   <= '0;
      sdata    <= 1'b0;
      underrun <= 1'b0;
    end else begin
      if (fall_evt) sdata <= slot_bit(word_nxt, pos_nxt, fmt_nxt);
      if (frame_start) begin
        underrun <= ~s_valid;
        if (s_valid) begin
          hold_l <= s_left;
          hold_r <= s_right;
        end
      end
    end
  end

  AST_HOLD_KEPT_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !s_valid) |=> ($stable(hold_l) && $stable(hold_r))); // R9
endmodule

// File: rtl/pcm_tx.sv
module pcm_tx
  import pcm_tx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DIV_W-1:0]    cfg_half_div,
  input  logic [1:0]          cfg_prec,
  input  logic                cfg_lsb_first,
  input  logic                cfg_short_slot,
  input  logic                cfg_right_align,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_left,
  input  logic [SAMPLE_W-1:0] s_right,
  output logic                bclk,
  output logic                lrclk,
  output logic                sdata,
  output logic                underrun
);
  localparam logic [DIV_W-1:0] MIN_HALF = DIV_W'(1);

  fmt_t             fmt_live;
  fmt_t             fmt_act;
  fmt_t             fmt_eff;
  fmt_t             fmt_nxt;
  logic [DIV_W-1:0] half_act;
  logic [DIV_W-1:0] half_raw;
  logic [DIV_W-1:0] half_eff;
  logic             primed;
  logic             fall_evt;
  logic             frame_start;
  logic [POS_W-1:0] pos_nxt;
  logic [POS_W-1:0] slot_last;
  logic             ch_nxt;

  assign fmt_live  = '{prec: cfg_prec, lsb_first: cfg_lsb_first,
                       short_slot: cfg_short_slot, right_align: cfg_right_align};
  assign fmt_eff   = primed ? fmt_act : fmt_live;
  assign fmt_nxt   = frame_start ? fmt_live : fmt_eff;
  assign half_raw  = primed ? half_act : cfg_half_div;
  assign half_eff  = (half_raw == '0) ? MIN_HALF : half_raw;
  assign slot_last = POS_W'(slot_cycles(fmt_eff) - 1);
  assign s_ready   = frame_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_act  <= '0;
      half_act <= '0;
      primed   <= 1'b0;
    end else if (frame_start) begin
      fmt_act  <= fmt_live;
      half_act <= cfg_half_div;
      primed   <= 1'b1;
    end
  end

  pcm_tx_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .half     (half_eff),
    .bclk     (bclk),
    .fall_evt (fall_evt)
  );

  pcm_tx_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .fall_evt    (fall_evt),
    .slot_last   (slot_last),
    .frame_start (frame_start),
    .pos_nxt     (pos_nxt),
    .ch_nxt      (ch_nxt),
    .lrclk       (lrclk)
  );

  pcm_tx_ser u_ser (
    .clk         (clk),
    .rst_n       (rst_n),
    .fall_evt    (fall_evt),
    .frame_start (frame_start),
    .s_valid     (s_valid),
    .s_left      (s_left),
    .s_right     (s_right),
    .ch_nxt      (ch_nxt),
    .pos_nxt     (pos_nxt),
    .fmt_nxt     (fmt_nxt),
    .sdata       (sdata),
    .underrun    (underrun)
  );

  AST_LR_ON_BCLK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lrclk) |-> $fell(bclk)); // R2
  AST_SD_ON_BCLK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata) |-> $fell(bclk)); // R3
  AST_READY_IN_RIGHT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (lrclk && bclk)); // R8
  AST_UNDERRUN_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(underrun) |-> $fell(lrclk)); // R9
  AST_FMT_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !frame_start) |=> ($stable(fmt_act) && $stable(half_act))); // R10
endmodule

// File: tb/pcm_tx_tb.sv
module pcm_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W      = 8;
  localparam int WATCHDOG   = 150000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [DIV_W-1:0] cfg_half_div = 8'd2;
  logic [1:0]       cfg_prec = 2'd3;
  logic             cfg_lsb_first = 1'b0;
  logic             cfg_short_slot = 1'b0;
  logic             cfg_right_align = 1'b0;
  logic             s_valid = 1'b1;
  logic             s_ready;
  logic [23:0]      s_left = 24'hA5C3F1;
  logic [23:0]      s_right = 24'h3C0F96;
  logic             bclk, lrclk, sdata, underrun;

  int    n_checks = 0;
  int    n_errors = 0;
  string cur_req = "R4";
  bit    finished = 1'b0;

  pcm_tx #(.DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_half_div(cfg_half_div), .cfg_prec(cfg_prec),
    .cfg_lsb_first(cfg_lsb_first), .cfg_short_slot(cfg_short_slot),
    .cfg_right_align(cfg_right_align), .s_valid(s_valid), .s_ready(s_ready),
    .s_left(s_left), .s_right(s_right), .bclk(bclk), .lrclk(lrclk),
    .sdata(sdata), .underrun(underrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int        m_cnt, m_half, m_frames;
  bit        m_bclk, m_lr, m_sd, m_und, m_primed;
  int        m_bits, m_slot;
  bit        m_lsb, m_right;
  bit [23:0] m_hl, m_hr;
  bit        q_sd[$];
  bit        q_lr[$];
  bit        acc;

  function automatic int fix_half(int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic push_slot(bit [23:0] smp, bit lr);
    bit word_seq[$];
    bit [23:0] w;
    w = smp >> (24 - m_bits);
    for (int i = 0; i < m_bits; i++)
      word_seq.push_back(m_lsb ? w[i] : w[m_bits - 1 - i]);
    if (m_right) for (int i = 0; i < m_slot - m_bits; i++) begin q_sd.push_back(1'b0); q_lr.push_back(lr); end
    foreach (word_seq[i]) begin q_sd.push_back(word_seq[i]); q_lr.push_back(lr); end
    if (!m_right) for (int i = 0; i < m_slot - m_bits; i++) begin q_sd.push_back(1'b0); q_lr.push_back(lr); end
  endtask

  task automatic model_fall();
    if (q_sd.size() == 0) begin
      m_primed = 1'b1;
      m_frames++;
      m_half  = fix_half(int'(cfg_half_div));
      m_bits  = (cfg_prec == 0) ? 16 : (cfg_prec == 1) ? 18 : (cfg_prec == 2) ? 20 : 24;
      m_slot  = (cfg_short_slot && cfg_prec == 0) ? 16 : 32;
      m_lsb   = cfg_lsb_first;
      m_right = cfg_right_align;
      if (s_valid) begin m_hl = s_left; m_hr = s_right; end
      m_und = !s_valid;
      push_slot(m_hl, 1'b0);
      push_slot(m_hr, 1'b1);
    end
    m_sd = q_sd.pop_front();
    m_lr = q_lr.pop_front();
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_half = 1; m_bclk = 0; m_lr = 1; m_sd = 0; m_und = 0;
      m_primed = 0; m_hl = '0; m_hr = '0; m_frames = 0;
      q_sd.delete(); q_lr.delete();
    end else begin
      int h;
      h = m_primed ? m_half : fix_half(int'(cfg_half_div));
      if (m_cnt >= h - 1) begin
        m_cnt = 0;
        if (m_bclk) model_fall();
        m_bclk = !m_bclk;
      end else begin
        m_cnt++;
      end
    end
    acc <= s_valid && s_ready;
  end

  // new sample pair after every accepted one
  always @(negedge clk) begin
    if (acc) begin
      s_left  <= 24'($urandom);
      s_right <= 24'($urandom);
    end
  end

  // ---------------- comparison on every cycle ----------------
  task automatic check(string req, string what, bit act, bit exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  bit prev_sd = 1'b0, prev_bclk = 1'b0;
  always begin
    @(negedge clk);
    #1;
    if (rst_n && !finished) begin
      int  h;
      bit  exp_rdy;
      h = m_primed ? m_half : fix_half(int'(cfg_half_div));
      exp_rdy = (m_cnt >= h - 1) && m_bclk && (q_sd.size() == 0);
      check("R1", "bclk", bclk, m_bclk);
      check("R2", "lrclk", lrclk, m_lr);
      check(cur_req, "sdata", sdata, m_sd);
      check("R8", "s_ready", s_ready, exp_rdy);
      check("R9", "underrun", underrun, m_und);
      // R3: data moves only together with a bclk fall
      check("R3", "sdata_on_fall", (sdata != prev_sd) && !(prev_bclk && !bclk), 1'b0);
    end
    prev_sd   = sdata;
    prev_bclk = bclk;
  end

  task automatic wait_frames(int n);
    int target;
    target = m_frames + n;
    while (m_frames < target) @(negedge clk);
  endtask

  task automatic set_fmt(logic [1:0] p, bit lsb, bit sh, bit ra);
    cfg_prec = p; cfg_lsb_first = lsb; cfg_short_slot = sh; cfg_right_align = ra;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset values
    check("R11", "bclk_rst", bclk, 1'b0);
    check("R11", "lrclk_rst", lrclk, 1'b1);
    check("R11", "sdata_rst", sdata, 1'b0);
    check("R11", "underrun_rst", underrun, 1'b0);
    check("R11", "ready_rst", s_ready, 1'b0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R11", "bclk_after_rst", bclk, 1'b0);
    check("R11", "lrclk_after_rst", lrclk, 1'b1);

    cur_req = "R4"; wait_frames(3);                          // 24-bit, MSB first
    cur_req = "R5"; set_fmt(2'd3, 1, 0, 0); wait_frames(3);  // LSB first
    cur_req = "R4"; set_fmt(2'd1, 0, 0, 0); wait_frames(2);  // 18 bit
    cur_req = "R7"; set_fmt(2'd2, 1, 0, 1); wait_frames(3);  // 20 bit right aligned
    cur_req = "R7"; set_fmt(2'd0, 0, 0, 1); wait_frames(2);  // 16 in 32, right
    cur_req = "R6"; set_fmt(2'd0, 0, 1, 0); wait_frames(3);  // 16-cycle slots
    cur_req = "R6"; set_fmt(2'd2, 0, 1, 0); wait_frames(2);  // short ignored for 20
    cur_req = "R1"; cfg_half_div = 8'd1; wait_frames(3);
    cur_req = "R1"; cfg_half_div = 8'd0; wait_frames(3);
    cur_req = "R1"; cfg_half_div = 8'd3; wait_frames(2);
    // R9: starve for two frames, then resume
    cur_req = "R9"; s_valid = 1'b0; wait_frames(2);
    s_valid = 1'b1; wait_frames(2);
    // R10: change everything halfway through a frame
    cur_req = "R10";
    repeat (150) @(negedge clk);
    set_fmt(2'd0, 1, 1, 1); cfg_half_div = 8'd2;
    wait_frames(2);
    repeat (37) @(negedge clk);
    set_fmt(2'd3, 0, 0, 1); cfg_half_div = 8'd1; s_valid = 1'b0;
    wait_frames(1);
    s_valid = 1'b1; wait_frames(2);
    // R8: toggle valid around the ready cycle
    cur_req = "R8";
    for (int i = 0; i < 4; i++) begin
      while (!s_ready) @(negedge clk);
      s_valid = i[0];
      @(negedge clk);
      s_valid = 1'b1;
      wait_frames(1);
    end
    wait_frames(1);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule